// File: doc/BRIEF.md
# Completion Interrupt Register File

This block collects transfer-completion events from a DMA engine and turns them into processor interrupts. Each completion event arrives as a one-cycle pulse carrying a completion code. The code picks one of `NUM_CODES` bits. Every bit has a pending flag and an enable flag. Software reaches the flags through a small word-addressed register port. That port has read views of the pending and enable flags, plus three write-one-only command registers: pending clear, enable set and enable clear.

A single combined interrupt output is raised while any bit is both pending and enabled. A pending flag is recorded even when its interrupt is disabled. This lets software take interrupts for some codes and poll the pending view for others. A flag stays pending until software clears it. If a new completion arrives in the same cycle as a clear for its bit, the new completion wins.

The register port uses these word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | Pending view | read |
| 1 | Enable view | read |
| 2 | Pending clear | write |
| 3 | Enable set | write |
| 4 | Enable clear | write |

Reads return data one cycle after `rd_en`. The returned value is the state just before that clock edge.

Top module: `cmpl_irq_regs`

## Requirements
- R1: After a synchronous active-high reset, all pending flags and all enable flags are 0, `irq` is 0 and `rd_data` is 0.
- R2: A cycle with `cmp_valid` high and `cmp_code` = k sets pending bit k and no other pending bit.
- R3: A pending bit is set by its completion even while its enable is 0, and `irq` then stays 0.
- R4: Writing the pending-clear register (address 2) clears each pending bit whose write-data bit is 1. Bits written 0 are left unchanged.
- R5: Writing the enable-set register (address 3) sets each enable bit whose write-data bit is 1. Bits written 0 are left unchanged.
- R6: Writing the enable-clear register (address 4) clears each enable bit whose write-data bit is 1. Bits written 0 are left unchanged, and pending bits are not affected.
- R7: `irq` is registered and equals the OR over all bits of (pending AND enable) as that state stands after each clock edge.
- R8: When a completion for code k and a pending-clear write with bit k set fall in the same cycle, pending bit k ends up set.
- R9: A read at address 0 returns the pending flags, and a read at address 1 returns the enable flags. Reads have no side effects. Reads at any other address return 0. `rd_data` is valid in the cycle after `rd_en`.
- R10: A completion code presented while `cmp_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Completion pulse strobe |
| cmp_code | input | $clog2(NUM_CODES) | Completion code selecting the bit |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | NUM_CODES | Write data, one bit per code |
| rd_data | output | NUM_CODES | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker watches several properties on every cycle:
- the interrupt output against the pending and enable state;
- that each completion lands in its bit;
- that write-one commands take effect;
- that a completion wins over a simultaneous clear;
- that no pending bit ever drops without a clear write.

Other behaviour only the bench's scenarios can show:
- read latency and the values returned at each address;
- the absence of read side effects;
- that zeros written to the command registers leave bits alone;
- that strobe-low codes are ignored.

The bench shows these by sweeping every completion code against both enabled and disabled states.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_ENSET = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENCLR = 3'd4;
endpackage

// File: rtl/cmpl_irq_decode.sv
module cmpl_irq_decode #(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 valid,
  input  logic [CODE_W-1:0]    code,
  output logic [NUM_CODES-1:0] hit
);
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_dec
    assign hit[i] = valid && (code == CODE_W'(i));
  end
endmodule

// File: rtl/cmpl_irq_regif.sv
module cmpl_irq_regif
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_CODES-1:0] wr_data,
  input  logic [NUM_CODES-1:0] pend_q,
  input  logic [NUM_CODES-1:0] en_q,
  output logic [NUM_CODES-1:0] clr_mask,
  output logic [NUM_CODES-1:0] enset_mask,
  output logic [NUM_CODES-1:0] enclr_mask,
  output logic [NUM_CODES-1:0] rd_data
);
  logic [NUM_CODES-1:0] rd_next;

  always_comb begin
    clr_mask   = (wr_en && addr == A_CLR)   ? wr_data : '0;
    enset_mask = (wr_en && addr == A_ENSET) ? wr_data : '0;
    enclr_mask = (wr_en && addr == A_ENCLR) ? wr_data : '0;
  end

  always_comb begin
    case (addr)
      A_PEND:  rd_next = pend_q;
      A_EN:    rd_next = en_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/cmpl_irq_flags.sv
module cmpl_irq_flags #(
  parameter int NUM_CODES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CODES-1:0] hit,
  input  logic [NUM_CODES-1:0] clr_mask,
  input  logic [NUM_CODES-1:0] enset_mask,
  input  logic [NUM_CODES-1:0] enclr_mask,
  output logic [NUM_CODES-1:0] pend_d,
  output logic [NUM_CODES-1:0] en_d,
  output logic [NUM_CODES-1:0] pend_q,
  output logic [NUM_CODES-1:0] en_q
);
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_bit
    // a new completion takes priority over a clear in the same cycle
    assign pend_d[i] = hit[i] | (pend_q[i] & ~clr_mask[i]);
    assign en_d[i]   = enset_mask[i] | (en_q[i] & ~enclr_mask[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        pend_q[i] <= pend_d[i];
        en_q[i]   <= en_d[i];
      end
    end
  end
endmodule

// File: rtl/cmpl_irq_combine.sv
module cmpl_irq_combine #(
  parameter int NUM_CODES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CODES-1:0] pend_d,
  input  logic [NUM_CODES-1:0] en_d,
  output logic                 irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend_d & en_d);
  end
endmodule

// File: rtl/cmpl_irq_regs.sv
module cmpl_irq_regs
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmp_valid,
  input  logic [CODE_W-1:0]    cmp_code,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_CODES-1:0] wr_data,
  output logic [NUM_CODES-1:0] rd_data,
  output logic                 irq
);
  logic [NUM_CODES-1:0] hit, clr_mask, enset_mask, enclr_mask;
  logic [NUM_CODES-1:0] pend_d, en_d, pend_q, en_q;

  cmpl_irq_decode #(.NUM_CODES(NUM_CODES)) u_decode (
    .valid(cmp_valid), .code(cmp_code), .hit(hit)
  );

  cmpl_irq_regif #(.NUM_CODES(NUM_CODES)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pend_q(pend_q), .en_q(en_q),
    .clr_mask(clr_mask), .enset_mask(enset_mask), .enclr_mask(enclr_mask),
    .rd_data(rd_data)
  );

  cmpl_irq_flags #(.NUM_CODES(NUM_CODES)) u_flags (
    .clk(clk), .rst(rst), .hit(hit), .clr_mask(clr_mask),
    .enset_mask(enset_mask), .enclr_mask(enclr_mask),
    .pend_d(pend_d), .en_d(en_d), .pend_q(pend_q), .en_q(en_q)
  );

  cmpl_irq_combine #(.NUM_CODES(NUM_CODES)) u_combine (
    .clk(clk), .rst(rst), .pend_d(pend_d), .en_d(en_d), .irq(irq)
  );
endmodule

// File: rtl/cmpl_irq_chk.sv
module cmpl_irq_chk
  import cmpl_irq_pkg::*;
#(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmp_valid,
  input logic [CODE_W-1:0]    cmp_code,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [NUM_CODES-1:0] wr_data,
  input logic [NUM_CODES-1:0] pend_q,
  input logic [NUM_CODES-1:0] en_q,
  input logic                 irq
);
  // R7
  irq_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend_q & en_q));

  // R2
  pulse_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> pend_q[$past(cmp_code)]);

  // R8
  pulse_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && wr_en && addr == A_CLR && wr_data[cmp_code]) |=> pend_q[$past(cmp_code)]);

  // R4
  clear_takes_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR && !cmp_valid) |=> (pend_q & $past(wr_data)) == '0);

  // R4
  pend_holds_without_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_CLR) |=> (pend_q & $past(pend_q)) == $past(pend_q));

  // R5
  enable_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENSET) |=> (en_q & $past(wr_data)) == $past(wr_data));

  // R6
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_ENCLR) |=> (en_q & $past(wr_data)) == '0);
endmodule

bind cmpl_irq_regs cmpl_irq_chk #(.NUM_CODES(NUM_CODES)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .pend_q(pend_q), .en_q(en_q), .irq(irq)
);

// File: tb/cmpl_irq_regs_tb.sv
`timescale 1ns/1ps
module cmpl_irq_regs_tb;
  localparam int N  = 32;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_valid = 1'b0;
  logic [CW-1:0] cmp_code = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] pend_m = '0, en_m = '0;

  always #2.5 clk = ~clk;

  cmpl_irq_regs #(.NUM_CODES(N)) u_dut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; return at the next falling edge
  task automatic tick(input logic v, input int code, input logic w, input logic r,
                      input logic [2:0] a, input logic [N-1:0] d);
    cmp_valid = v; cmp_code = CW'(code); wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(posedge clk);
    if (w && a == 3'd2) pend_m = pend_m & ~d;
    if (v)              pend_m = pend_m | (N'(1) << code);
    if (w && a == 3'd3) en_m = en_m | d;
    if (w && a == 3'd4) en_m = en_m & ~d;
    @(negedge clk);
    cmp_valid = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    tick(1'b0, 0, 1'b0, 1'b1, a, '0);
    v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    tick(1'b0, 0, 1'b1, 1'b0, a, d);
  endtask

  task automatic pulse(input int code);
    tick(1'b1, code, 1'b0, 1'b0, 3'd0, '0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", N'(irq), '0);
    check("R1 rd_data", rd_data, '0);
    rd(3'd0, v); check("R1 pending", v, '0);
    rd(3'd1, v); check("R1 enable", v, '0);

    // R2 R3 R4: every code with interrupts disabled
    for (int k = 0; k < N; k++) begin
      pulse(k);
      check("R3 irq stays low", N'(irq), '0);
      rd(3'd0, v); check("R2 one bit per code", v, N'(1) << k);
      wr(3'd2, N'(1) << k);
      rd(3'd0, v); check("R4 clear", v, '0);
    end

    // R10 strobe low ignored
    tick(1'b0, 5, 1'b0, 1'b0, 3'd0, '0);
    rd(3'd0, v); check("R10 no strobe", v, '0);

    // R5 R6 enables, zeros have no effect
    wr(3'd3, 32'hA5A5_0F0F);
    rd(3'd1, v); check("R5 set", v, 32'hA5A5_0F0F);
    wr(3'd3, 32'h0000_00F0);
    rd(3'd1, v); check("R5 zeros kept", v, 32'hA5A5_0FFF);
    wr(3'd4, 32'h0000_000F);
    rd(3'd1, v); check("R6 clear", v, 32'hA5A5_0FF0);

    // R7 irq per code against enable
    for (int k = 0; k < N; k++) begin
      pulse(k);
      check("R7 irq follows enable", N'(irq), N'(en_m[k]));
      wr(3'd2, N'(1) << k);
      check("R7 irq drops after clear", N'(irq), '0);
    end

    // R4 partial clear
    pulse(1); pulse(2); pulse(9); pulse(30);
    wr(3'd2, (N'(1) << 2) | (N'(1) << 30));
    rd(3'd0, v); check("R4 zeros kept", v, pend_m);
    check("R4 model", pend_m, (N'(1) << 1) | (N'(1) << 9));

    // R9 read without side effects, unmapped address reads zero
    rd(3'd0, v); rd(3'd0, v2);
    check("R9 stable reread", v2, v);
    rd(3'd2, v); check("R9 write-only reads 0", v, '0);
    rd(3'd7, v); check("R9 unmapped reads 0", v, '0);
    check("R9 irq after reads", N'(irq), N'(|(pend_m & en_m)));

    // R8 completion wins over same-cycle clear
    wr(3'd2, '1);
    tick(1'b1, 7, 1'b1, 1'b0, 3'd2, N'(1) << 7);
    rd(3'd0, v); check("R8 same bit", v, N'(1) << 7);
    tick(1'b1, 3, 1'b1, 1'b0, 3'd2, '1);
    rd(3'd0, v); check("R8 other bits cleared", v, N'(1) << 3);

    // R6 disabling keeps pending, drops irq
    wr(3'd2, '1);
    wr(3'd3, N'(1) << 12);
    pulse(12);
    check("R7 irq on enabled", N'(irq), N'(1));
    wr(3'd4, N'(1) << 12);
    check("R6 irq off", N'(irq), '0);
    rd(3'd0, v); check("R6 pending kept", v, N'(1) << 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule